// File: doc/BRIEF.md
# RV32I Integer Execute Unit

This block is the integer datapath of a 32-bit core's execute stage. It reads a raw 32-bit instruction word with the two source operand values and the address of that instruction. From these it produces the value to be written to the destination register, together with a write strobe. It has no clock and no state. The answer settles in the same cycle in which the inputs are presented, so the surrounding pipeline decides where to register it.

The opcode field is decoded directly. The unit recognises four instruction groups:
- register-immediate arithmetic (opcode 0010011)
- register-register arithmetic (opcode 0110011)
- load-upper-immediate (opcode 0110111)
- add-upper-immediate-to-pc (opcode 0010111)

Within the two arithmetic groups, funct3 (bits 14:12) picks the operation:

| funct3 | Operation |
|--------|-----------|
| 000 | add (or subtract) |
| 001 | left shift |
| 010 | signed set-less-than |
| 011 | unsigned set-less-than |
| 100 | xor |
| 101 | right shift |
| 110 | or |
| 111 | and |

Bit 30 selects subtract (register form only) and arithmetic right shift. Any other encoding is flagged as illegal and never writes.

Top module: `rv32i_int_exec`

## Requirements
- R1: Add (funct3 000, bit 30 clear, either form) and register subtract (funct3 000, bit 30 set, register form) return the low 32 bits of the exact result, so overflow wraps silently. In the immediate form, bit 30 is part of the immediate and never selects subtract.
- R2: Signed set-less-than (funct3 010) returns 1 when rs1 is below the second operand as a two's-complement number, else 0. The second operand is the sign-extended immediate (instruction bits 31:20) or rs2.
- R3: Unsigned set-less-than (funct3 011) returns 1 or 0 under unsigned order. The immediate form first sign-extends its 12-bit immediate to 32 bits and then reads it as unsigned, so an immediate of 1 yields 1 only for rs1 = 0, and an immediate of 0xFFF compares against 0xFFFFFFFF.
- R4: And, or and xor (funct3 111, 110, 100) operate bitwise on rs1 and rs2 or the sign-extended immediate. An xor immediate of all ones returns the inverse of rs1.
- R5: Immediate shifts take the amount from instruction bits 24:20. For funct3 101, bit 30 set selects arithmetic right shift (sign fill) and bit 30 clear selects logical right shift (zero fill). For funct3 001, the shift is left with zero fill.
- R6: Register shifts use only bits 4:0 of rs2 as the amount. All higher bits of rs2 are ignored.
- R7: Load-upper-immediate returns instruction bits 31:12 in result bits 31:12 with bits 11:0 zero. Add-upper-immediate-to-pc returns that same value plus pc, modulo 2^32.
- R8: A legal instruction whose destination field (bits 11:7) is zero drives rd_we low, so an add-immediate of 0 to x0 into x0 changes nothing.
- R9: Any encoding outside the four groups, or with funct7 (bits 31:25) not permitted for its funct3, raises illegal, holds rd_we low and drives rd_data to zero. Permitted funct7 values are:
  - immediate left shift: 0000000 only
  - immediate right shift: 0000000 or 0100000
  - register add and register right shift: 0000000 or 0100000
  - all other register operations: 0000000 only
- R10: Every legal encoding holds illegal low and, with a nonzero destination field, drives rd_we high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Raw instruction word |
| rs1_val | input | 32 | Value of the first source register |
| rs2_val | input | 32 | Value of the second source register |
| pc | input | 32 | Address of the instruction |
| rd_data | output | 32 | Result for the destination register |
| rd_we | output | 1 | Destination write strobe |
| illegal | output | 1 | Encoding not recognised |

## Verification
The unit is purely combinational, so a wrong decode or operand choice shows at the ports as soon as the inputs are applied, in the same cycle. A mistaken immediate build or operand select shows up as a wrong rd_data. A mistaken legality decision shows as an incorrect illegal or rd_we value. Because nothing is stored, a fault never lingers into the next instruction. Each operand pattern therefore exposes its own fault on its own.

// File: rtl/rv32i_int_exec.sv
module rv32i_int_exec (
  input  logic [31:0] instr,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  input  logic [31:0] pc,
  output logic [31:0] rd_data,
  output logic        rd_we,
  output logic        illegal
);
  localparam int XW = 32;
  localparam int SW = $clog2(XW);

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] F7_BASE   = 7'b0000000;
  localparam logic [6:0] F7_ALT    = 7'b0100000;

  logic [6:0] opc;
  logic [4:0] dst;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       alt;

  assign opc = instr[6:0];
  assign dst = instr[11:7];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign alt = instr[30];

  logic is_imm, is_reg, is_lui, is_auipc;
  assign is_imm   = (opc == OPC_IMM);
  assign is_reg   = (opc == OPC_REG);
  assign is_lui   = (opc == OPC_LUI);
  assign is_auipc = (opc == OPC_AUIPC);

  logic [XW-1:0] imm_i, imm_u;
  assign imm_i = {{(XW-12){instr[31]}}, instr[31:20]};
  assign imm_u = {instr[31:12], 12'b0};

  logic [XW-1:0] opb;
  logic [SW-1:0] shamt;
  assign opb   = is_reg ? rs2_val : imm_i;
  assign shamt = opb[SW-1:0];

  logic legal;
  always_comb begin
    legal = 1'b0;
    if (is_lui || is_auipc) legal = 1'b1;
    else if (is_imm) begin
      case (f3)
        3'b001:  legal = (f7 == F7_BASE);
        3'b101:  legal = (f7 == F7_BASE) || (f7 == F7_ALT);
        default: legal = 1'b1;
      endcase
    end else if (is_reg) begin
      case (f3)
        3'b000, 3'b101: legal = (f7 == F7_BASE) || (f7 == F7_ALT);
        default:        legal = (f7 == F7_BASE);
      endcase
    end
  end

  logic [XW-1:0] alu;
  always_comb begin
    case (f3)
      3'b000:  alu = (is_reg && alt) ? rs1_val - opb : rs1_val + opb;
      3'b001:  alu = rs1_val << shamt;
      3'b010:  alu = {{(XW-1){1'b0}}, $signed(rs1_val) < $signed(opb)};
      3'b011:  alu = {{(XW-1){1'b0}}, rs1_val < opb};
      3'b100:  alu = rs1_val ^ opb;
      3'b101:  alu = alt ? XW'($signed(rs1_val) >>> shamt) : rs1_val >> shamt;
      3'b110:  alu = rs1_val | opb;
      default: alu = rs1_val & opb;
    endcase
  end

  always_comb begin
    if (!legal)        rd_data = '0;
    else if (is_lui)   rd_data = imm_u;
    else if (is_auipc) rd_data = pc + imm_u;
    else               rd_data = alu;
  end

  assign illegal = !legal;
  assign rd_we   = legal && (dst != 5'd0);

  always_comb begin
    // R8
    if (dst == 5'd0) x0_nowrite_chk: assert (!rd_we);
    // R9
    if (illegal) illegal_quiet_chk: assert (!rd_we && rd_data == '0);
    // R2
    if (!illegal && (is_imm || is_reg) && f3 == 3'b010) slt_bool_chk: assert (rd_data[XW-1:1] == '0);
    // R3
    if (!illegal && (is_imm || is_reg) && f3 == 3'b011) sltu_bool_chk: assert (rd_data[XW-1:1] == '0);
    // R7
    if (!illegal && is_lui) lui_low_zero_chk: assert (rd_data[11:0] == 12'd0);
    // R5
    if (!illegal && (is_imm || is_reg) && f3 == 3'b101 && !alt && shamt != '0)
      srl_zero_fill_chk: assert (!rd_data[XW-1]);
  end
endmodule

// File: tb/rv32i_int_exec_bench.sv
module rv32i_int_exec_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, rs1_val, rs2_val, pc, rd_data;
  logic rd_we, illegal;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rv32i_int_exec u_rv32i_int_exec (
    .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc),
    .rd_data(rd_data), .rd_we(rd_we), .illegal(illegal));

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [2:0] f3, logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [2:0] f3, logic [4:0] rd);
    return {f7, 5'd2, 5'd1, f3, rd, 7'b0110011};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic [31:0] p);
    @(posedge clk);
    instr = i; rs1_val = a; rs2_val = b; pc = p;
    @(negedge clk);
  endtask

  task automatic expect_ok(string tag, logic [31:0] exp);
    chk(tag, rd_data, exp);
    chk({tag, " we"}, {31'd0, rd_we}, 32'd1);
    chk({tag, " ill"}, {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_zero_word;
    apply(32'd0, 32'h1234, 32'h5678, 32'h0);
    chk("R9 zero word ill", {31'd0, illegal}, 32'd1);
    chk("R9 zero word we", {31'd0, rd_we}, 32'd0);
  endtask

  task automatic t_arith;
    apply(enc_i(12'd1, 3'b000, 5'd3), 32'h7fffffff, 0, 0);
    expect_ok("R1 addi wrap", 32'h80000000);
    apply(enc_i(12'h800, 3'b000, 5'd3), 32'h10, 0, 0);
    expect_ok("R1 addi neg", 32'hfffff810);
    apply(enc_r(7'b0100000, 3'b000, 5'd3), 32'h0, 32'h1, 0);
    expect_ok("R1 sub wrap R10", 32'hffffffff);
    apply(enc_r(7'b0000000, 3'b000, 5'd3), 32'hffffffff, 32'h2, 0);
    expect_ok("R1 add wrap", 32'h1);
  endtask

  task automatic t_slt;
    apply(enc_i(12'd3, 3'b010, 5'd4), 32'hfffffffb, 0, 0);
    expect_ok("R2 slti neg", 32'd1);
    apply(enc_r(7'b0, 3'b010, 5'd4), 32'h80000000, 32'h1, 0);
    expect_ok("R2 slt", 32'd1);
    apply(enc_r(7'b0, 3'b010, 5'd4), 32'h5, 32'h5, 0);
    expect_ok("R2 slt equal", 32'd0);
  endtask

  task automatic t_sltu;
    apply(enc_i(12'd1, 3'b011, 5'd4), 32'h0, 0, 0);
    expect_ok("R3 sltiu seqz", 32'd1);
    apply(enc_i(12'd1, 3'b011, 5'd4), 32'h5, 0, 0);
    expect_ok("R3 sltiu nz", 32'd0);
    apply(enc_i(12'hfff, 3'b011, 5'd4), 32'h12345678, 0, 0);
    expect_ok("R3 sltiu sext", 32'd1);
    apply(enc_r(7'b0, 3'b011, 5'd4), 32'h80000000, 32'h1, 0);
    expect_ok("R3 sltu", 32'd0);
  endtask

  task automatic t_logic;
    apply(enc_i(12'hfff, 3'b100, 5'd5), 32'hdeadbeef, 0, 0);
    expect_ok("R4 xori not", ~32'hdeadbeef);
    apply(enc_i(12'h800, 3'b111, 5'd5), 32'h1234abcd, 0, 0);
    expect_ok("R4 andi sext", 32'h1234a800);
    apply(enc_r(7'b0, 3'b110, 5'd5), 32'hf0f00000, 32'h0000f0f0, 0);
    expect_ok("R4 or", 32'hf0f0f0f0);
    apply(enc_r(7'b0, 3'b100, 5'd5), 32'hff00ff00, 32'h0ff00ff0, 0);
    expect_ok("R4 xor", 32'hf0f0f0f0);
  endtask

  task automatic t_shift_imm;
    apply(enc_i({7'b0100000, 5'd4}, 3'b101, 5'd6), 32'h80000010, 0, 0);
    expect_ok("R5 srai", 32'hf8000001);
    apply(enc_i({7'b0000000, 5'd4}, 3'b101, 5'd6), 32'h80000010, 0, 0);
    expect_ok("R5 srli", 32'h08000001);
    apply(enc_i({7'b0000000, 5'd31}, 3'b001, 5'd6), 32'h3, 0, 0);
    expect_ok("R5 slli", 32'h80000000);
  endtask

  task automatic t_shift_reg;
    apply(enc_r(7'b0100000, 3'b101, 5'd7), 32'h80000000, 32'hffffffe4, 0);
    expect_ok("R6 sra mask", 32'hf8000000);
    apply(enc_r(7'b0, 3'b101, 5'd7), 32'h80000000, 32'h00000024, 0);
    expect_ok("R6 srl mask", 32'h08000000);
    apply(enc_r(7'b0, 3'b001, 5'd7), 32'h1, 32'h00000120, 0);
    expect_ok("R6 sll mask", 32'h1);
  endtask

  task automatic t_upper;
    apply({20'habcde, 5'd8, 7'b0110111}, 32'h1, 32'h2, 32'h4000);
    expect_ok("R7 lui", 32'habcde000);
    apply({20'hfffff, 5'd8, 7'b0010111}, 0, 0, 32'h1000);
    expect_ok("R7 auipc wrap", 32'h0);
    apply({20'h00012, 5'd8, 7'b0010111}, 0, 0, 32'h00000400);
    expect_ok("R7 auipc", 32'h00012400);
  endtask

  task automatic t_x0;
    apply(enc_i(12'd0, 3'b000, 5'd0), 32'h55, 0, 0);
    chk("R8 nop we", {31'd0, rd_we}, 32'd0);
    chk("R8 nop ill", {31'd0, illegal}, 32'd0);
    apply(enc_r(7'b0, 3'b000, 5'd0), 32'h1, 32'h1, 0);
    chk("R8 add x0 we", {31'd0, rd_we}, 32'd0);
  endtask

  task automatic t_illegal;
    logic [31:0] bad [4];
    bad[0] = enc_r(7'b0000001, 3'b000, 5'd9);
    bad[1] = enc_i({7'b0100000, 5'd3}, 3'b001, 5'd9);
    bad[2] = {25'h0, 7'b1100011};
    bad[3] = enc_r(7'b0100000, 3'b001, 5'd9);
    for (int k = 0; k < 4; k++) begin
      apply(bad[k], 32'hffffffff, 32'h3, 32'h100);
      chk("R9 illegal flag", {31'd0, illegal}, 32'd1);
      chk("R9 illegal we", {31'd0, rd_we}, 32'd0);
      chk("R9 illegal data", rd_data, 32'd0);
    end
  endtask

  initial begin
    instr = '0; rs1_val = '0; rs2_val = '0; pc = '0;
    t_zero_word();
    t_arith();
    t_slt();
    t_sltu();
    t_logic();
    t_shift_imm();
    t_shift_reg();
    t_upper();
    t_x0();
    t_illegal();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule